// File: doc/BRIEF.md
# Dwell-Weighted Waveform Rasterizer

This block builds an intensity-graded picture of a sampled waveform, in the way the phosphor of an analog scope glows brighter where the trace lingers. A stream of 8-bit samples enters one per clock with a valid strobe. Each group of a programmable number of consecutive samples forms one screen column. Inside that column, every sample adds one hit to the pixel whose row equals its amplitude. Amplitudes the signal holds for a long time collect many hits, and fast edges collect few.

A clear command starts a frame. It zeroes the whole raster and takes a new samples-per-column setting. Once the last column is full, a done flag rises and the frame stops taking samples. Software or a display engine then reads any pixel through a pipelined port. The port returns an 8-bit intensity: the pixel's hit count scaled against the column's sample total, so a pixel hit by every sample of its column reads full scale. The full screen is 400 columns by 256 rows. The column count is a parameter, and its default is small enough for quick elaboration.

Top module: `dwell_raster`

## Requirements
- R1: After reset, `frameDone` is 0, every pixel reads 0, the samples-per-column setting is 1 and filling starts at column 0, so `NUM_COLS` accepted samples complete a frame without any clear.
- R2: An accepted sample adds one hit to the pixel whose row equals `sampleData` (0..255) and whose column is floor(k / S), where k counts the samples accepted since the last clear or reset (from 0) and S is the active samples-per-column setting.
- R3: A pixel with hit count c reads as floor(min(c, 1023) * 255 / S), clamped to 255. With S = 1 every lit pixel therefore reads 255.
- R4: Hit counters saturate at 1023 (`CNT_W` = 10) and do not wrap. For example, 1100 hits with S = 1100 read 237.
- R5: `frameDone` rises at the clock edge that accepts the last sample of column `NUM_COLS`-1. It stays high until a clear, and samples that arrive while it is high change no pixel.
- R6: A clear zeroes every pixel, restarts at column 0, drops `frameDone` and loads S from `samplesPerCol`, with 0 taken as 1. A clear wins over a sample in the same cycle, and that sample is dropped. Changes on `samplesPerCol` between clears have no effect.
- R7: A read request on `rdEn` returns `rdData` with `rdValid` high exactly two clock cycles later, and `rdValid` is never high otherwise.
- R8: Cycles with `sampleValid` low change no pixel and do not advance the column position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Sample strobe |
| sampleData | input | 8 | Sample amplitude, used as the row index |
| samplesPerCol | input | SPC_W (16) | Samples per column, loaded on clear |
| clearFrame | input | 1 | Clears the raster and starts a new frame |
| frameDone | output | 1 | Last column complete |
| rdEn | input | 1 | Pixel read request |
| rdCol | input | COL_W (3) | Read column |
| rdRow | input | 8 | Read row |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8 | Pixel intensity |

## Verification
A sample presented before a clock edge is counted at that edge. A pixel read launched one cycle later already sees the new count, and `frameDone` is visible right after the edge that takes the final sample. Read data is due at the second edge after the request, so the bench drives the request on a falling edge and samples `rdData` and `rdValid` on the falling edge after that second rising edge. Each sample also updates a bench model of hit counts and column position at the same edge, and every expected intensity comes from that model through the scaling rule in R3. A clear is held for exactly one edge, so the model is reset in step with the design.

// File: rtl/dwell_raster_pkg.sv
package dwell_raster_pkg;
  localparam int SAMPLE_W = 8;
  localparam int NUM_ROWS = 1 << SAMPLE_W;
  localparam int INTENS_W = 8;

  // strobes the control hands to the datapath each cycle
  typedef struct packed {
    logic wrEn;      // count one hit at the current column / sample row
    logic clearAll;  // wipe every pixel
  } ctrlStrobes_t;
endpackage

// File: rtl/dwell_raster_ctrl.sv
module dwell_raster_ctrl
  import dwell_raster_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int SPC_W    = 16,
  parameter int COL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             clearFrame,
  input  logic [SPC_W-1:0] samplesPerCol,
  output ctrlStrobes_t     strobes,
  output logic [COL_W-1:0] curCol,
  output logic [SPC_W-1:0] spcEff,
  output logic             frameDone
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  logic [SPC_W-1:0] spcReg;
  logic [SPC_W-1:0] sampIdx;
  logic [COL_W-1:0] colIdx;
  logic             doneReg;
  logic             accept;
  logic             lastInCol;
  logic             lastCol;

  assign accept    = sampleValid && !clearFrame && !doneReg;
  assign lastInCol = (sampIdx == spcReg - SPC_W'(1));
  assign lastCol   = (colIdx == LAST_COL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spcReg  <= SPC_W'(1);
      sampIdx <= '0;
      colIdx  <= '0;
      doneReg <= 1'b0;
    end else if (clearFrame) begin
      spcReg  <= (samplesPerCol == '0) ? SPC_W'(1) : samplesPerCol;
      sampIdx <= '0;
      colIdx  <= '0;
      doneReg <= 1'b0;
    end else if (accept) begin
      if (lastInCol) begin
        sampIdx <= '0;
        if (lastCol) doneReg <= 1'b1;
        else         colIdx  <= colIdx + COL_W'(1);
      end else begin
        sampIdx <= sampIdx + SPC_W'(1);
      end
    end
  end

  always_comb begin
    strobes.wrEn     = accept;
    strobes.clearAll = clearFrame;
  end

  assign curCol    = colIdx;
  assign spcEff    = spcReg;
  assign frameDone = doneReg;
endmodule

// File: rtl/dwell_raster_datapath.sv
module dwell_raster_datapath
  import dwell_raster_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 10,
  parameter int SPC_W    = 16,
  parameter int COL_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [COL_W-1:0]    wrCol,
  input  logic [SAMPLE_W-1:0] wrRow,
  input  logic [SPC_W-1:0]    spcEff,
  input  logic                rdEn,
  input  logic [COL_W-1:0]    rdCol,
  input  logic [SAMPLE_W-1:0] rdRow,
  output logic                rdValid,
  output logic [INTENS_W-1:0] rdData
);
  localparam int PIX    = NUM_COLS * NUM_ROWS;
  localparam int ADDR_W = COL_W + SAMPLE_W;
  localparam int PROD_W = CNT_W + INTENS_W;
  localparam int DIV_W  = (PROD_W > SPC_W) ? PROD_W : SPC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntMem [PIX];
  logic [PIX-1:0]   pixLive;

  // hit path: one read-modify-write per accepted sample
  logic [ADDR_W-1:0] wrAddr;
  logic [CNT_W-1:0]  oldCnt;
  logic [CNT_W-1:0]  newCnt;

  assign wrAddr = {wrCol, wrRow};
  assign oldCnt = pixLive[wrAddr] ? cntMem[wrAddr] : '0;
  assign newCnt = (oldCnt == CNT_MAX) ? oldCnt : oldCnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (strobes.wrEn) cntMem[wrAddr] <= newCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pixLive         <= '0;
    else if (strobes.clearAll) pixLive         <= '0;
    else if (strobes.wrEn)     pixLive[wrAddr] <= 1'b1;
  end

  // read path stage 1: fetch count
  logic [ADDR_W-1:0] rdAddr;
  logic              rdInRange;
  logic              rdP1Valid;
  logic [CNT_W-1:0]  rdCnt;

  assign rdAddr = {rdCol, rdRow};

  generate
    if (NUM_COLS == (1 << COL_W)) begin : gFullRange
      assign rdInRange = 1'b1;
    end else begin : gPartRange
      assign rdInRange = (rdCol < COL_W'(NUM_COLS));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdP1Valid <= 1'b0;
      rdCnt     <= '0;
    end else begin
      rdP1Valid <= rdEn;
      if (rdEn) rdCnt <= (rdInRange && pixLive[rdAddr]) ? cntMem[rdAddr] : '0;
    end
  end

  // read path stage 2: scale against the column sample total
  logic [DIV_W-1:0]    prod;
  logic [DIV_W-1:0]    quot;
  logic [INTENS_W-1:0] scaled;

  assign prod   = DIV_W'(rdCnt) * DIV_W'((1 << INTENS_W) - 1);
  assign quot   = prod / DIV_W'(spcEff);
  assign scaled = (quot > DIV_W'((1 << INTENS_W) - 1)) ? '1 : quot[INTENS_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdP1Valid;
      if (rdP1Valid) rdData <= scaled;
    end
  end
endmodule

// File: rtl/dwell_raster.sv
module dwell_raster
  import dwell_raster_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 10,
  parameter int SPC_W    = 16,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SPC_W-1:0]    samplesPerCol,
  input  logic                clearFrame,
  output logic                frameDone,
  input  logic                rdEn,
  input  logic [COL_W-1:0]    rdCol,
  input  logic [SAMPLE_W-1:0] rdRow,
  output logic                rdValid,
  output logic [INTENS_W-1:0] rdData
);
  ctrlStrobes_t     strobes;
  logic [COL_W-1:0] curCol;
  logic [SPC_W-1:0] spcEff;

  dwell_raster_ctrl #(
    .NUM_COLS(NUM_COLS), .SPC_W(SPC_W), .COL_W(COL_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .clearFrame(clearFrame),
    .samplesPerCol(samplesPerCol), .strobes(strobes), .curCol(curCol),
    .spcEff(spcEff), .frameDone(frameDone)
  );

  dwell_raster_datapath #(
    .NUM_COLS(NUM_COLS), .CNT_W(CNT_W), .SPC_W(SPC_W), .COL_W(COL_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrCol(curCol), .wrRow(sampleData),
    .spcEff(spcEff), .rdEn(rdEn), .rdCol(rdCol), .rdRow(rdRow),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/dwell_raster_checker.sv
module dwell_raster_checker (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic clearFrame,
  input logic frameDone,
  input logic rdEn,
  input logic rdValid
);
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !clearFrame) |=> frameDone);

  assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> $past(sampleValid));

  assert_clear_drops_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    clearFrame |=> !frameDone);

  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn, 2) |-> rdValid);

  assert_rd_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn, 2));
endmodule

bind dwell_raster dwell_raster_checker uChk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .clearFrame(clearFrame),
  .frameDone(frameDone), .rdEn(rdEn), .rdValid(rdValid)
);

// File: tb/dwell_raster_test.sv
module dwell_raster_test;
  localparam int COLS = 8;
  localparam int COLW = 3;
  localparam int SPCW = 16;
  localparam int CNTMAX = 1023;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            sampleValid = 1'b0;
  logic [7:0]      sampleData = '0;
  logic [SPCW-1:0] samplesPerCol = '0;
  logic            clearFrame = 1'b0;
  logic            frameDone;
  logic            rdEn = 1'b0;
  logic [COLW-1:0] rdCol = '0;
  logic [7:0]      rdRow = '0;
  logic            rdValid;
  logic [7:0]      rdData;

  dwell_raster #(.NUM_COLS(COLS)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .samplesPerCol(samplesPerCol), .clearFrame(clearFrame), .frameDone(frameDone),
    .rdEn(rdEn), .rdCol(rdCol), .rdRow(rdRow), .rdValid(rdValid), .rdData(rdData)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int expCnt [COLS][256];
  int expSpc, expCol, expSamp;
  bit expDone;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expIntensity(input int c, input int r);
    int cnt = (expCnt[c][r] > CNTMAX) ? CNTMAX : expCnt[c][r];
    int q = cnt * 255 / expSpc;
    return (q > 255) ? 255 : q;
  endfunction

  task automatic modelClear(input int spc);
    foreach (expCnt[c, r]) expCnt[c][r] = 0;
    expSpc = (spc == 0) ? 1 : spc;
    expCol = 0; expSamp = 0; expDone = 0;
  endtask

  task automatic doClear(input int spc);
    @(negedge clk);
    sampleValid = 0; samplesPerCol = SPCW'(spc); clearFrame = 1;
    @(negedge clk);
    clearFrame = 0;
    modelClear(spc);
  endtask

  // present one input cycle; the model follows the edge that takes it
  task automatic pushSample(input bit v, input int val);
    @(negedge clk);
    sampleValid = v; sampleData = 8'(val);
    if (v && !expDone) begin
      expCnt[expCol][val]++;
      expSamp++;
      if (expSamp == expSpc) begin
        expSamp = 0;
        if (expCol == COLS - 1) expDone = 1; else expCol++;
      end
    end
  endtask

  task automatic readPixel(input int c, input int r, output int d, output int v);
    @(negedge clk);
    sampleValid = 0; rdEn = 1; rdCol = COLW'(c); rdRow = 8'(r);
    @(negedge clk);
    rdEn = 0;
    @(negedge clk);
    d = rdData; v = rdValid;
  endtask

  task automatic checkPixel(input string tag, input int c, input int r, input int exp);
    int d, v;
    readPixel(c, r, d, v);
    check({tag, " rdValid"}, v, 1);
    check($sformatf("%s pixel(%0d,%0d)", tag, c, r), d, exp);
  endtask

  task automatic checkFrame(input string tag);
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < 256; r++) begin
        int d, v;
        readPixel(c, r, d, v);
        check($sformatf("%s pixel(%0d,%0d)", tag, c, r), d, expIntensity(c, r));
      end
  endtask

  task automatic checkDone(input string tag);
    @(negedge clk);
    sampleValid = 0;
    check(tag, int'(frameDone), int'(expDone));
  endtask

  task automatic randomFrame(input int spc, input int base);
    doClear(spc);
    while (!expDone) begin
      bit v = ($urandom % 4) != 0;
      int val = (base + int'($urandom % 12)) % 256;
      if (($urandom % 16) == 0) val = int'($urandom % 256);
      samplesPerCol = SPCW'($urandom % 50);  // R6: ignored until next clear
      pushSample(v, val);
    end
    checkDone("R5 frame done after random fill");
    checkFrame("R2/R3 random frame");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d, v;
    void'($urandom(32'd20240611));
    modelClear(1);
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    checkDone("R1 frameDone after reset");
    checkPixel("R1 reset", 0, 0, 0);
    checkPixel("R1 reset", 7, 255, 0);
    checkPixel("R1 reset", 3, 128, 0);
    // R1 default one sample per column; R8 idle cycles do not advance
    for (int i = 0; i < COLS; i++) begin
      pushSample(1, 20 + 3 * i);
      pushSample(0, 99);
    end
    checkDone("R1 done after NUM_COLS samples");
    checkPixel("R3 single-sample column full scale", 5, 35, 255);
    checkPixel("R8 invalid cycle ignored", 0, 99, 0);
    checkFrame("R1/R2 default frame");

    // R5 samples after done change nothing
    for (int i = 0; i < 5; i++) pushSample(1, 9);
    checkDone("R5 done stays high");
    checkPixel("R5 ignored after done", 7, 9, 0);
    checkPixel("R5 last pixel kept", 7, 41, 255);

    // R6 clear wipes the raster
    doClear(3);
    checkDone("R6 clear drops done");
    checkPixel("R6 cleared pixel", 5, 35, 0);
    checkPixel("R6 cleared pixel", 7, 41, 0);

    // R3 dwell weighting with ten samples per column
    doClear(10);
    for (int i = 0; i < 7; i++) pushSample(1, 10);
    for (int i = 0; i < 3; i++) pushSample(1, 200);
    pushSample(1, 11);
    checkPixel("R3 dwell 7 of 10", 0, 10, 178);
    checkPixel("R3 dwell 3 of 10", 0, 200, 76);
    checkPixel("R2 next column starts", 1, 11, 25);

    // R6 clear beats a sample in the same cycle
    @(negedge clk);
    samplesPerCol = 4; clearFrame = 1; sampleValid = 1; sampleData = 55;
    @(negedge clk);
    clearFrame = 0; sampleValid = 0;
    modelClear(4);
    checkPixel("R6 sample dropped under clear", 0, 55, 0);
    for (int i = 0; i < 4; i++) pushSample(1, 55);
    pushSample(1, 56);
    checkPixel("R2 four of four", 0, 55, 255);
    checkPixel("R2 column boundary", 1, 56, 63);
    checkPixel("R2 no spill into column 0", 0, 56, 0);

    // R6 a setting of zero acts as one
    doClear(0);
    for (int i = 0; i < COLS; i++) pushSample(1, 200 - i);
    checkDone("R6 zero setting acts as one");
    checkPixel("R6 zero setting full scale", 2, 198, 255);

    // R4 saturation
    doClear(1100);
    for (int i = 0; i < 1100; i++) pushSample(1, 77);
    checkDone("R4 not done after one column");
    checkPixel("R4 saturated count", 0, 77, 237);

    // constrained random frames; R6 setting changes between clears ignored
    randomFrame(3, 40);
    randomFrame(1 + int'($urandom % 30), 100);
    randomFrame(17, 250);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule